// File: doc/BRIEF.md
# DMA Line-Splitting Sequencer

This block takes one DMA transfer at a time, given as a byte address, a byte length, a kind code and a write payload. It turns that transfer into a series of cache-line chunk requests. Each chunk names a line-aligned address, a byte offset inside the line, a byte count, a direction flag and, for writes, the payload bytes placed at their line positions with a matching byte-enable mask. Only the first chunk may start in the middle of a line. Every chunk after it begins at offset zero.

Only one chunk is outstanding at a time. The next chunk goes out only after the memory side has answered the previous one, either with a data line for a read or with an acknowledge for a write. Read data is gathered into a transfer buffer at the transfer's byte positions. When every byte has been answered, the block pulses a completion strobe carrying the ID that was handed out when the transfer was accepted.

Top module: `dma_line_seq`

## Requirements
- R1: `req_ready` is high exactly when no transfer is active. On acceptance, `req_id` carries the transfer ID. IDs count up by one per accepted transfer, starting at 0 after reset and wrapping at 2^ID_W.
- R2: A request is legal only with kind code 1 (load) or 2 (store) and a length from 1 to BUF_BYTES. Codes 0, 3 (fetch) and 4 (atomic) are illegal, as are lengths outside that range. An illegal request raises `req_err` in the same cycle, starts no transfer and consumes no ID.
- R3: The first chunk has offset = address mod LINE_BYTES and length = min(len, LINE_BYTES − offset). Its line address is the address with the low offset bits cleared.
- R4: Each later chunk has offset 0, line address = start address + bytes already answered, and length = min(remaining bytes, LINE_BYTES).
- R5: After a chunk is accepted (`ck_valid && ck_ready`), `ck_valid` stays low until a response is taken.
- R6: While `ck_valid` is high and `ck_ready` is low, every chunk field holds its value.
- R7: For a write chunk, `ck_be` bit j is set exactly for offset ≤ j < offset + length. Byte j of `ck_data` is payload byte (bytes answered + j − offset) where the enable bit is set, and zero elsewhere.
- R8: A read response copies line bytes [offset, offset + length) into `rd_data` bytes [answered, answered + length). The offset is nonzero only on the first chunk. When the completion strobe is seen, `rd_data` bytes 0..len−1 hold the transfer's data.
- R9: The cycle after the response that completes the transfer, `done_valid` is high for exactly one cycle with `done_id` equal to the accepted ID, and `req_ready` is high again.
- R10: A response arriving when no chunk is outstanding raises `rsp_err` in the same cycle. Such a response is otherwise ignored: it produces no completion and no chunk.
- R11: `ck_write` is 1 for every chunk of a store and 0 for every chunk of a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_kind | input | 3 | Kind code: 1 load, 2 store, others illegal |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Transfer length in bytes |
| req_wdata | input | BUF_BYTES*8 | Write payload, byte k at bits [8k+7:8k] |
| req_id | output | ID_W | ID given to the transfer on acceptance |
| req_err | output | 1 | Illegal request presented while idle |
| ck_valid | output | 1 | Chunk request valid |
| ck_ready | input | 1 | Chunk accepted by memory side |
| ck_write | output | 1 | Chunk is a write |
| ck_line_addr | output | ADDR_W | Line-aligned chunk address |
| ck_offset | output | OFF_W | Start byte within the line |
| ck_len | output | CL_W | Chunk byte count |
| ck_data | output | LINE_BYTES*8 | Write payload placed at line positions |
| ck_be | output | LINE_BYTES | Byte enables of the chunk |
| rsp_valid | input | 1 | Read data or write acknowledge |
| rsp_data | input | LINE_BYTES*8 | Returned line for reads |
| rsp_err | output | 1 | Response with no chunk outstanding |
| done_valid | output | 1 | Transfer complete strobe |
| done_id | output | ID_W | ID of the completed transfer |
| rd_data | output | BUF_BYTES*8 | Gathered read bytes |

## Verification
The bench sweeps every start offset in an 8-byte line against every length from 1 to the 32-byte buffer size, in both directions, and computes each chunk arithmetically. This covers single bytes at the last line position, transfers that end exactly on a line boundary and first chunks that are clipped. A design that forgot to clip the first chunk would spill past the line end. A design that kept the start offset on later chunks would leave holes and misplaced bytes in the gathered read data. A design that advanced its count on acceptance rather than on response would issue the next chunk too early or finish early with a wrong ID. Chunk stalls, illegal kinds and lengths, and stray responses while idle check that held fields stay put and that rejected stimulus leaves no trace at the ports.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [2:0] {
    KIND_NONE   = 3'd0,
    KIND_LOAD   = 3'd1,
    KIND_STORE  = 3'd2,
    KIND_FETCH  = 3'd3,
    KIND_ATOMIC = 3'd4
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/dma_chunk_calc.sv
// Works out address, offset and length of the chunk at the current progress.
module dma_chunk_calc #(
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 6,
  parameter int LINE_BYTES = 8,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CL_W      = $clog2(LINE_BYTES + 1)
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic [LEN_W-1:0]  done_bytes,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] line_addr,
  output logic [OFF_W-1:0]  offset,
  output logic [CL_W-1:0]   clen,
  output logic              first
);

  localparam int CW = ((LEN_W > CL_W) ? LEN_W : CL_W) + 1;

  logic [CW-1:0] remain_w;
  logic [CW-1:0] room_w;

  always_comb begin
    cur_addr  = start_addr + ADDR_W'(done_bytes);
    first     = (done_bytes == '0);
    offset    = first ? start_addr[OFF_W-1:0] : '0;
    line_addr = {cur_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    remain_w  = CW'(xfer_len) - CW'(done_bytes);
    room_w    = CW'(LINE_BYTES) - CW'(offset);
    clen      = (remain_w < room_w) ? CL_W'(remain_w) : CL_W'(room_w);
  end

endmodule

// File: rtl/dma_wr_pack.sv
// Places payload bytes at their line positions and builds the byte enables.
module dma_wr_pack #(
  parameter int LEN_W      = 6,
  parameter int LINE_BYTES = 8,
  parameter int BUF_BYTES  = 32,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CL_W      = $clog2(LINE_BYTES + 1),
  localparam int BI_W      = $clog2(BUF_BYTES)
) (
  input  logic [BUF_BYTES*8-1:0]  wbuf,
  input  logic [LEN_W-1:0]        done_bytes,
  input  logic [OFF_W-1:0]        offset,
  input  logic [CL_W-1:0]         clen,
  output logic [LINE_BYTES*8-1:0] line_data,
  output logic [LINE_BYTES-1:0]   be
);

  for (genvar j = 0; j < LINE_BYTES; j++) begin : g_lane
    int              src;
    logic            hit;
    logic [BI_W-1:0] idx;

    always_comb begin
      src = int'(done_bytes) + j - int'(offset);
      hit = (j >= int'(offset)) && (j < int'(offset) + int'(clen)) &&
            (src >= 0) && (src < BUF_BYTES);
      idx = hit ? BI_W'(src) : '0;
      be[j] = hit;
      line_data[j*8 +: 8] = hit ? wbuf[int'(idx)*8 +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/dma_rd_gather.sv
// Transfer buffer that collects returned read bytes at their transfer positions.
module dma_rd_gather #(
  parameter int LEN_W      = 6,
  parameter int LINE_BYTES = 8,
  parameter int BUF_BYTES  = 32,
  localparam int OFF_W     = $clog2(LINE_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    capture,
  input  logic [LEN_W-1:0]        done_bytes,
  input  logic [LEN_W-1:0]        n_bytes,
  input  logic [OFF_W-1:0]        src_off,
  input  logic [LINE_BYTES*8-1:0] line_data,
  output logic [BUF_BYTES*8-1:0]  buf_q
);

  logic [BUF_BYTES*8-1:0] buf_d;
  logic [BUF_BYTES-1:0]   byte_en;

  for (genvar k = 0; k < BUF_BYTES; k++) begin : g_byte
    int               src;
    logic [OFF_W-1:0] idx;

    always_comb begin
      src = k - int'(done_bytes) + int'(src_off);
      byte_en[k] = capture && (k >= int'(done_bytes)) &&
                   (k < int'(done_bytes) + int'(n_bytes)) &&
                   (src >= 0) && (src < LINE_BYTES);
      idx = byte_en[k] ? OFF_W'(src) : '0;
      buf_d[k*8 +: 8] = line_data[int'(idx)*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        buf_q[k*8 +: 8] <= 8'h00;
      end else if (byte_en[k]) begin
        buf_q[k*8 +: 8] <= buf_d[k*8 +: 8];
      end
    end
  end

endmodule

// File: rtl/dma_line_seq.sv
// One-transfer-at-a-time sequencer that splits a byte range into line chunks.
module dma_line_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 8,
  parameter int BUF_BYTES  = 32,
  parameter int ID_W       = 4,
  localparam int LEN_W     = $clog2(BUF_BYTES + 1),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CL_W      = $clog2(LINE_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [2:0]              req_kind,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LEN_W-1:0]        req_len,
  input  logic [BUF_BYTES*8-1:0]  req_wdata,
  output logic [ID_W-1:0]         req_id,
  output logic                    req_err,
  output logic                    ck_valid,
  input  logic                    ck_ready,
  output logic                    ck_write,
  output logic [ADDR_W-1:0]       ck_line_addr,
  output logic [OFF_W-1:0]        ck_offset,
  output logic [CL_W-1:0]         ck_len,
  output logic [LINE_BYTES*8-1:0] ck_data,
  output logic [LINE_BYTES-1:0]   ck_be,
  input  logic                    rsp_valid,
  input  logic [LINE_BYTES*8-1:0] rsp_data,
  output logic                    rsp_err,
  output logic                    done_valid,
  output logic [ID_W-1:0]         done_id,
  output logic [BUF_BYTES*8-1:0]  rd_data
);

  // ---------------------------------------------------------------- state
  seq_state_e             state_q, state_d;
  logic [ADDR_W-1:0]      addr_q;
  logic [LEN_W-1:0]       len_q;
  logic                   wr_q;
  logic [BUF_BYTES*8-1:0] wbuf_q;
  logic [ID_W-1:0]        id_ctr_q, id_ctr_d;
  logic [ID_W-1:0]        xid_q;
  logic [LEN_W-1:0]       issued_q, issued_d;
  logic [LEN_W-1:0]       answered_q, answered_d;
  logic                   done_q, done_d;

  logic                   legal;
  logic                   accept;
  logic                   ck_fire;
  logic                   rsp_take;

  logic [ADDR_W-1:0]      cur_addr;
  logic [ADDR_W-1:0]      line_addr;
  logic [OFF_W-1:0]       chunk_off;
  logic [CL_W-1:0]        chunk_len;
  logic                   chunk_first;
  logic [LINE_BYTES*8-1:0] pack_data;
  logic [LINE_BYTES-1:0]  pack_be;

  // ---------------------------------------------------------- submodules
  dma_chunk_calc #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .LINE_BYTES (LINE_BYTES)
  ) u_calc (
    .start_addr (addr_q),
    .xfer_len   (len_q),
    .done_bytes (answered_q),
    .cur_addr   (cur_addr),
    .line_addr  (line_addr),
    .offset     (chunk_off),
    .clen       (chunk_len),
    .first      (chunk_first)
  );

  dma_wr_pack #(
    .LEN_W      (LEN_W),
    .LINE_BYTES (LINE_BYTES),
    .BUF_BYTES  (BUF_BYTES)
  ) u_pack (
    .wbuf       (wbuf_q),
    .done_bytes (answered_q),
    .offset     (chunk_off),
    .clen       (chunk_len),
    .line_data  (pack_data),
    .be         (pack_be)
  );

  dma_rd_gather #(
    .LEN_W      (LEN_W),
    .LINE_BYTES (LINE_BYTES),
    .BUF_BYTES  (BUF_BYTES)
  ) u_gather (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (rsp_take && !wr_q),
    .done_bytes (answered_q),
    .n_bytes    (issued_q - answered_q),
    .src_off    (chunk_off),
    .line_data  (rsp_data),
    .buf_q      (rd_data)
  );

  // ----------------------------------------------------------- next state
  always_comb begin
    legal = ((req_kind == KIND_LOAD) || (req_kind == KIND_STORE)) &&
            (req_len != '0) && (int'(req_len) <= BUF_BYTES);
    accept   = req_valid && (state_q == ST_IDLE) && legal;
    ck_fire  = (state_q == ST_ISSUE) && ck_ready;
    rsp_take = (state_q == ST_WAIT) && rsp_valid;

    state_d    = state_q;
    id_ctr_d   = id_ctr_q;
    issued_d   = issued_q;
    answered_d = answered_q;
    done_d     = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d    = ST_ISSUE;
          id_ctr_d   = id_ctr_q + 1'b1;
          issued_d   = '0;
          answered_d = '0;
        end
      end
      ST_ISSUE: begin
        if (ck_fire) begin
          state_d  = ST_WAIT;
          issued_d = issued_q + LEN_W'(chunk_len);
        end
      end
      ST_WAIT: begin
        if (rsp_take) begin
          answered_d = issued_q;
          if (issued_q == len_q) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = ST_ISSUE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // ------------------------------------------------------------ registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      id_ctr_q   <= '0;
      issued_q   <= '0;
      answered_q <= '0;
      done_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      id_ctr_q   <= id_ctr_d;
      issued_q   <= issued_d;
      answered_q <= answered_d;
      done_q     <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      len_q  <= '0;
      wr_q   <= 1'b0;
      wbuf_q <= '0;
      xid_q  <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      len_q  <= req_len;
      wr_q   <= (req_kind == KIND_STORE);
      wbuf_q <= req_wdata;
      xid_q  <= id_ctr_q;
    end
  end

  // --------------------------------------------------------------- outputs
  always_comb begin
    req_ready    = (state_q == ST_IDLE);
    req_id       = id_ctr_q;
    req_err      = req_valid && (state_q == ST_IDLE) && !legal;
    ck_valid     = (state_q == ST_ISSUE);
    ck_write     = wr_q;
    ck_line_addr = line_addr;
    ck_offset    = chunk_off;
    ck_len       = chunk_len;
    ck_data      = wr_q ? pack_data : '0;
    ck_be        = pack_be;
    rsp_err      = rsp_valid && (state_q != ST_WAIT);
    done_valid   = done_q;
    done_id      = xid_q;
  end

  // ------------------------------------------------------------ assertions
  // R6
  ck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_valid && !ck_ready) |=> (ck_valid && $stable(ck_line_addr) &&
      $stable(ck_offset) && $stable(ck_len) && $stable(ck_data) && $stable(ck_be)));

  // R4
  later_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_valid && !chunk_first) |-> (cur_addr[OFF_W-1:0] == '0));

  // R3
  line_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ck_valid |-> ((int'(ck_offset) + int'(ck_len)) <= LINE_BYTES));

  // R7
  be_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ck_valid |-> ($countones(ck_be) == int'(ck_len)));

  // R5
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_valid && ck_ready) |=> !ck_valid);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (req_ready && !$past(done_valid)));

endmodule

// File: tb/dma_line_seq_tb.sv
`timescale 1ns/1ps
module dma_line_seq_tb;

  localparam int ADDR_W     = 16;
  localparam int LINE_BYTES = 8;
  localparam int BUF_BYTES  = 32;
  localparam int ID_W       = 4;
  localparam int LEN_W      = $clog2(BUF_BYTES + 1);
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int CL_W       = $clog2(LINE_BYTES + 1);

  logic                    clk;
  logic                    rst_n;
  logic                    req_valid;
  logic                    req_ready;
  logic [2:0]              req_kind;
  logic [ADDR_W-1:0]       req_addr;
  logic [LEN_W-1:0]        req_len;
  logic [BUF_BYTES*8-1:0]  req_wdata;
  logic [ID_W-1:0]         req_id;
  logic                    req_err;
  logic                    ck_valid;
  logic                    ck_ready;
  logic                    ck_write;
  logic [ADDR_W-1:0]       ck_line_addr;
  logic [OFF_W-1:0]        ck_offset;
  logic [CL_W-1:0]         ck_len;
  logic [LINE_BYTES*8-1:0] ck_data;
  logic [LINE_BYTES-1:0]   ck_be;
  logic                    rsp_valid;
  logic [LINE_BYTES*8-1:0] rsp_data;
  logic                    rsp_err;
  logic                    done_valid;
  logic [ID_W-1:0]         done_id;
  logic [BUF_BYTES*8-1:0]  rd_data;

  dma_line_seq #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .BUF_BYTES  (BUF_BYTES),
    .ID_W       (ID_W)
  ) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_kind     (req_kind),
    .req_addr     (req_addr),
    .req_len      (req_len),
    .req_wdata    (req_wdata),
    .req_id       (req_id),
    .req_err      (req_err),
    .ck_valid     (ck_valid),
    .ck_ready     (ck_ready),
    .ck_write     (ck_write),
    .ck_line_addr (ck_line_addr),
    .ck_offset    (ck_offset),
    .ck_len       (ck_len),
    .ck_data      (ck_data),
    .ck_be        (ck_be),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .rsp_err      (rsp_err),
    .done_valid   (done_valid),
    .done_id      (done_id),
    .rd_data      (rd_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int exp_id  = 0;

  function automatic logic [7:0] mem_byte(input int a);
    return 8'((a * 13) + (a >> 8) + 5);
  endfunction

  function automatic logic [7:0] pay_byte(input int k, input int seed);
    return 8'((k * 29) + seed);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL R9 watchdog expired act=%0d exp=<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic run_xfer(input int addr, input int len, input bit wr, input int seed);
    int done_b;
    int ci;
    logic [BUF_BYTES*8-1:0] wv;
    for (int k = 0; k < BUF_BYTES; k++) wv[k*8 +: 8] = pay_byte(k, seed);

    @(negedge clk);
    chk(done_valid == 1'b0, "R9 strobe is one cycle", 64'(done_valid), 0);
    req_valid = 1'b1;
    req_kind  = wr ? 3'd2 : 3'd1;
    req_addr  = 16'(addr);
    req_len   = LEN_W'(len);
    req_wdata = wv;
    #1;
    chk(req_ready && !req_err, "R1 ready when idle", {req_ready, req_err}, 2'b10);
    chk(req_id == ID_W'(exp_id), "R1 transfer id", 64'(req_id), 64'(exp_id % 16));
    @(negedge clk);
    req_valid = 1'b0;
    done_b = 0;
    ci = 0;
    while (done_b < len) begin
      int eoff, eclen, eline, room;
      bit dok;
      eoff  = (done_b == 0) ? (addr % LINE_BYTES) : 0;
      room  = LINE_BYTES - eoff;
      eclen = ((len - done_b) < room) ? (len - done_b) : room;
      eline = ((addr + done_b) / LINE_BYTES) * LINE_BYTES;
      chk(ck_valid && !req_ready, "R1 R5 chunk valid, busy", {ck_valid, req_ready}, 2'b10);
      if (done_b == 0)
        chk(ck_offset == OFF_W'(eoff) && ck_len == CL_W'(eclen) &&
            ck_line_addr == 16'(eline), "R3 first chunk",
            {ck_line_addr, 8'(ck_offset), 8'(ck_len)}, {16'(eline), 8'(eoff), 8'(eclen)});
      else
        chk(ck_offset == '0 && ck_len == CL_W'(eclen) && ck_line_addr == 16'(eline),
            "R4 later chunk", {ck_line_addr, 8'(ck_offset), 8'(ck_len)},
            {16'(eline), 8'(0), 8'(eclen)});
      chk(ck_write == wr, "R11 chunk direction", 64'(ck_write), 64'(wr));
      if (wr) begin
        dok = 1'b1;
        for (int j = 0; j < LINE_BYTES; j++) begin
          bit en;
          logic [7:0] eb;
          en = (j >= eoff) && (j < eoff + eclen);
          eb = en ? pay_byte(done_b + j - eoff, seed) : 8'h00;
          if (ck_be[j] != en || ck_data[j*8 +: 8] != eb) dok = 1'b0;
        end
        chk(dok, "R7 write payload and enables", ck_data, 64'(ck_be));
      end
      if (((len + ci) % 3) == 0) begin
        logic [ADDR_W-1:0] h_line;
        logic [LINE_BYTES*8-1:0] h_data;
        h_line = ck_line_addr;
        h_data = ck_data;
        ck_ready = 1'b0;
        @(negedge clk);
        chk(ck_valid && ck_line_addr == h_line && ck_data == h_data &&
            ck_len == CL_W'(eclen), "R6 held under stall", ck_data, h_data);
      end
      ck_ready = 1'b1;
      @(negedge clk);
      ck_ready = 1'b0;
      chk(!ck_valid, "R5 no chunk before response", 64'(ck_valid), 0);
      @(negedge clk);
      chk(!ck_valid, "R5 still waiting", 64'(ck_valid), 0);
      rsp_valid = 1'b1;
      for (int j = 0; j < LINE_BYTES; j++) rsp_data[j*8 +: 8] = mem_byte(eline + j);
      #1;
      chk(!rsp_err, "R10 no error when outstanding", 64'(rsp_err), 0);
      @(negedge clk);
      rsp_valid = 1'b0;
      done_b += eclen;
      ci++;
    end
    chk(done_valid && done_id == ID_W'(exp_id) && req_ready, "R9 completion",
        {done_valid, 8'(done_id), req_ready}, {1'b1, 8'(exp_id % 16), 1'b1});
    if (!wr) begin
      bit rok;
      rok = 1'b1;
      for (int k = 0; k < len; k++)
        if (rd_data[k*8 +: 8] != mem_byte(addr + k)) rok = 1'b0;
      chk(rok, "R8 gathered read data", rd_data[63:0], 64'(mem_byte(addr)));
    end
    exp_id = (exp_id + 1) % 16;
  endtask

  task automatic bad_req(input logic [2:0] kind, input int len);
    @(negedge clk);
    req_valid = 1'b1;
    req_kind  = kind;
    req_addr  = 16'h0040;
    req_len   = LEN_W'(len);
    #1;
    chk(req_err, "R2 illegal request flagged", 64'(req_err), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready && !ck_valid, "R2 no transfer started", {req_ready, ck_valid}, 2'b10);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_kind = 3'd0; req_addr = '0; req_len = '0; req_wdata = '0;
    ck_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0;
    #1;
    chk(req_ready && !ck_valid && !done_valid && !rsp_err && !req_err,
        "R1 reset state", {req_ready, ck_valid, done_valid, rsp_err}, 4'b1000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2: illegal kinds and lengths
    bad_req(3'd0, 4);
    bad_req(3'd3, 4);
    bad_req(3'd4, 4);
    bad_req(3'd1, 0);
    bad_req(3'd2, BUF_BYTES + 1);

    // R10: stray response while idle
    @(negedge clk);
    rsp_valid = 1'b1;
    #1;
    chk(rsp_err, "R10 stray response flagged", 64'(rsp_err), 1);
    @(negedge clk);
    rsp_valid = 1'b0;
    chk(!done_valid && !ck_valid && req_ready, "R10 stray response ignored",
        {done_valid, ck_valid, req_ready}, 3'b001);

    // Sweep every start offset and length, both directions
    for (int len = 1; len <= BUF_BYTES; len++)
      for (int off = 0; off < LINE_BYTES; off++)
        for (int d = 0; d < 2; d++)
          run_xfer(((len % 4) * 256) + 64 + off, len, d[0], len * 7 + off);

    // ID continues after the sweep (wrap covered)
    run_xfer(16'h07F7, 9, 1'b0, 3);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule